// File: doc/BRIEF.md
# PATA PIO Strobe Timing Generator

This block produces the read and write strobes for programmed-I/O transfers on a parallel ATA bus. It is clocked from the roughly 33 MHz PCI clock, so each count is one period of about 30 ns. Four device units are served: two channels with two devices each, numbered `2 * channel + device`. Each unit owns a 16-bit timing word. One byte of the word times reads and the other times writes. Within a byte, the active and recovery lengths are held as complemented nybble counts.

A small register write port loads the timing words and a per-unit mode byte. A mode bit marks its unit as running DMA, or as running with IORDY ignored. When the bit is clear, a low IORDY stretches the active phase. Changes to the mode byte wait until both posted-write-buffer busy flags are clear.

A request port accepts a unit number and a direction while the block is idle. The block then runs one strobe cycle made of an active phase and a recovery phase, and pulses `cycle_done` in the last recovery clock.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset every timing word is 0x0000 and every mode bit is clear, so an unprogrammed unit runs a 17-clock active phase and a 16-clock recovery phase. The block comes out of reset idle: `req_ready` high, both strobes low and `cycle_done` low.
- R2: A cycle uses the timing word of the unit given on `req_unit` (unit = 2*channel + device). Unit n's word is written at `cfg_addr` = 0x44 + 2n.
- R3: The low nybble N of the selected timing byte sets the active length to 17 - N clocks, which covers the range 2..17.
- R4: The high nybble M of the selected timing byte sets the recovery length to 16 - M clocks, which covers the range 1..16.
- R5: Reads are timed by bits [7:0] of the unit's word and writes by bits [15:8].
- R6: During the active phase `strobe_rd` is high for a read and `strobe_wr` is high for a write. The two strobes are never high together.
- R7: When the unit's mode bit is clear, the active phase ends at the first clock edge where both of these hold: the programmed count has elapsed, and IORDY, delayed by IORDY_SYNC (default 2) synchronizer flops, is high. If IORDY is released after the cycle is accepted, the strobe lasts max(active, j + 3) clocks, where j is the number of clocks from acceptance to the release.
- R8: Bit 4+n of the mode byte, written at `cfg_addr` 0x42 in `cfg_wdata[7:0]`, makes unit n ignore IORDY. Its active phase is then exactly the programmed count.
- R9: A mode-byte write made while `wbuf_busy` is non-zero is held back. It takes effect at the first clock where `wbuf_busy` is 2'b00. A write made while `wbuf_busy` is zero applies at once.
- R10: `cycle_done` is high for exactly one clock, in the last recovery clock. `req_ready` is high only when the block is idle, and a request presented while it is low is ignored.
- R11: A timing-word write made during a cycle leaves that cycle unchanged and applies from the next accepted cycle.
- R12: Writes to any address other than 0x42 and 0x44..0x4A (even) change neither the timing nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 16 | Register write data |
| wbuf_busy | input | 2 | Posted write buffer busy flags |
| req_valid | input | 1 | Cycle request |
| req_unit | input | 2 | Unit number, 2*channel + device |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| iordy | input | 1 | Device ready line, asynchronous |
| req_ready | output | 1 | Idle, so a request can be accepted |
| strobe_rd | output | 1 | Read strobe, active high |
| strobe_wr | output | 1 | Write strobe, active high |
| cycle_done | output | 1 | One-clock pulse at the end of recovery |

## Verification
A request is accepted on the clock edge where it is sampled with `req_ready` high. The strobe is high from the next clock for the active length, and `cycle_done` appears in the R-th clock after the strobe falls; the block is idle one clock after that. A register write is visible to any request accepted on a later edge. An IORDY release made j clocks after acceptance reaches the strobe engine three edges later. The bench drives all inputs and samples all outputs on the falling edge. It measures strobe and recovery widths by counting falling-edge samples, which compares whole-clock lengths against the values derived from the requirement formulas without depending on same-edge ordering.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

   localparam int NYB_W    = 4;
   localparam int CNT_W    = 5;
   localparam int WORD_W   = 16;
   // longest active and recovery lengths, reached with a zero nybble
   localparam int ACT_SPAN = 17;
   localparam int REC_SPAN = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_REC  = 2'd2
   } pio_state_e;

   // counter preload = length - 1
   function automatic logic [CNT_W-1:0] act_preload(input logic [NYB_W-1:0] nyb);
      return CNT_W'(ACT_SPAN - 1) - {1'b0, nyb};
   endfunction

   function automatic logic [CNT_W-1:0] rec_preload(input logic [NYB_W-1:0] nyb);
      return CNT_W'(REC_SPAN - 1) - {1'b0, nyb};
   endfunction

endpackage

// File: rtl/pio_tmg_regs.sv
module pio_tmg_regs #(
   parameter int          UNITS       = 4,
   parameter int          ADDR_W      = 8,
   parameter int          BUSY_W      = 2,
   parameter logic [7:0]  TIMING_BASE = 8'h44,
   parameter logic [7:0]  MODE_ADDR   = 8'h42,
   parameter int          MODE_LSB    = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic [ADDR_W-1:0]                      cfg_addr,
   input  logic [pio_tmg_pkg::WORD_W-1:0]         cfg_wdata,
   input  logic [BUSY_W-1:0]                      wbuf_busy,
   output logic [UNITS-1:0][pio_tmg_pkg::WORD_W-1:0] timing_words,
   output logic [UNITS-1:0]                       mode_bits
);
   import pio_tmg_pkg::*;

   logic             mode_sel;
   logic             bufs_clear;
   logic             pend_q;
   logic [UNITS-1:0] pend_val_q;
   logic [UNITS-1:0] mode_q;

   assign mode_sel   = cfg_we && (cfg_addr == ADDR_W'(MODE_ADDR));
   assign bufs_clear = (wbuf_busy == '0);

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      localparam logic [ADDR_W-1:0] UADDR = ADDR_W'(TIMING_BASE + 2*u);
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && (cfg_addr == UADDR))
            word_q <= cfg_wdata;
      end

      assign timing_words[u] = word_q;
   end

   // mode byte: applied only when no posted write is outstanding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= '0;
         pend_q     <= 1'b0;
         pend_val_q <= '0;
      end else if (mode_sel) begin
         if (bufs_clear) begin
            mode_q <= cfg_wdata[MODE_LSB +: UNITS];
            pend_q <= 1'b0;
         end else begin
            pend_q     <= 1'b1;
            pend_val_q <= cfg_wdata[MODE_LSB +: UNITS];
         end
      end else if (pend_q && bufs_clear) begin
         mode_q <= pend_val_q;
         pend_q <= 1'b0;
      end
   end

   assign mode_bits = mode_q;

   // R9: mode bits hold still while any write buffer is busy
   a_r9_mode_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wbuf_busy != '0) |=> $stable(mode_q));

   // R9: an outstanding change lands as soon as the buffers drain
   a_r9_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && bufs_clear && !mode_sel) |=> (!pend_q && mode_q == $past(pend_val_q)));

endmodule

// File: rtl/pio_tmg_sync.sv
module pio_tmg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain_q <= '0;
         else if (STAGES == 1)
            chain_q <= din;
         else
            chain_q <= STAGES'({chain_q, din});
      end

      assign dout = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pio_tmg_engine.sv
module pio_tmg_engine #(
   parameter int UNITS  = 4,
   parameter int UNIT_W = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [UNIT_W-1:0]                      req_unit,
   input  logic                                   req_write,
   input  logic [UNITS-1:0][pio_tmg_pkg::WORD_W-1:0] timing_words,
   input  logic [UNITS-1:0]                       mode_bits,
   input  logic                                   iordy_s,
   output logic                                   req_ready,
   output logic                                   strobe_rd,
   output logic                                   strobe_wr,
   output logic                                   cycle_done
);
   import pio_tmg_pkg::*;

   pio_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NYB_W-1:0] rec_nyb_q;
   logic             wr_q;
   logic             honor_q;
   logic [WORD_W-1:0] sel_word;
   logic [7:0]       sel_byte;
   logic             cnt_zero;

   assign sel_word = timing_words[req_unit];
   assign sel_byte = req_write ? sel_word[15:8] : sel_word[7:0];
   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         rec_nyb_q <= '0;
         wr_q      <= 1'b0;
         honor_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q   <= ST_ACT;
                  cnt_q     <= act_preload(sel_byte[3:0]);
                  rec_nyb_q <= sel_byte[7:4];
                  wr_q      <= req_write;
                  honor_q   <= !mode_bits[req_unit];
               end
            end
            ST_ACT: begin
               if (!cnt_zero)
                  cnt_q <= cnt_q - 1'b1;
               else if (!honor_q || iordy_s) begin
                  state_q <= ST_REC;
                  cnt_q   <= rec_preload(rec_nyb_q);
               end
            end
            ST_REC: begin
               if (!cnt_zero)
                  cnt_q <= cnt_q - 1'b1;
               else
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign strobe_rd  = (state_q == ST_ACT) && !wr_q;
   assign strobe_wr  = (state_q == ST_ACT) &&  wr_q;
   assign cycle_done = (state_q == ST_REC) && cnt_zero;

   // R6: never both strobes
   a_r6_strobe_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe_rd, strobe_wr}));

   // R10: accepted request starts the strobe on the next clock
   a_r10_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (strobe_rd || strobe_wr));

   // R10: done is a single-clock pulse followed by idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> (!cycle_done && req_ready));

   // R10: no ready while a strobe is driven
   a_r10_ready_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(strobe_rd || strobe_wr || cycle_done));

   // R3: shortest active phase is two clocks
   a_r3_min_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_rd || strobe_wr) |=> (strobe_rd || strobe_wr));

   // R4: at least one recovery clock after every strobe
   a_r4_recovery_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_rd || strobe_wr) |-> (!req_ready && !strobe_rd && !strobe_wr));

   // R8: with IORDY ignored, an expired count always leaves the active phase
   a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACT && cnt_zero && !honor_q) |=> (state_q == ST_REC));

   // R7: a low IORDY holds the strobe once the count is used up
   a_r7_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACT && cnt_zero && honor_q && !iordy_s) |=> (state_q == ST_ACT));

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
   parameter int          UNITS       = 4,
   parameter int          ADDR_W      = 8,
   parameter int          BUSY_W      = 2,
   parameter int          IORDY_SYNC  = 2,
   parameter logic [7:0]  TIMING_BASE = 8'h44,
   parameter logic [7:0]  MODE_ADDR   = 8'h42,
   parameter int          MODE_LSB    = 4,
   localparam int         UNIT_W      = (UNITS > 1) ? $clog2(UNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic [BUSY_W-1:0] wbuf_busy,
   input  logic              req_valid,
   input  logic [UNIT_W-1:0] req_unit,
   input  logic              req_write,
   input  logic              iordy,
   output logic              req_ready,
   output logic              strobe_rd,
   output logic              strobe_wr,
   output logic              cycle_done
);
   import pio_tmg_pkg::*;

   if (UNITS < 1 || MODE_LSB + UNITS > 8) begin : g_bad_units
      $error("pio_strobe_gen: UNITS must fit the mode byte above MODE_LSB");
   end
   if (IORDY_SYNC < 0 || IORDY_SYNC > 4) begin : g_bad_sync
      $error("pio_strobe_gen: IORDY_SYNC must be 0..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("pio_strobe_gen: ADDR_W must hold the register offsets");
   end

   logic [UNITS-1:0][WORD_W-1:0] timing_words;
   logic [UNITS-1:0]             mode_bits;
   logic                         iordy_s;

   pio_tmg_regs #(
      .UNITS       (UNITS),
      .ADDR_W      (ADDR_W),
      .BUSY_W      (BUSY_W),
      .TIMING_BASE (TIMING_BASE),
      .MODE_ADDR   (MODE_ADDR),
      .MODE_LSB    (MODE_LSB)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .wbuf_busy    (wbuf_busy),
      .timing_words (timing_words),
      .mode_bits    (mode_bits)
   );

   pio_tmg_sync #(
      .STAGES (IORDY_SYNC)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (iordy),
      .dout  (iordy_s)
   );

   pio_tmg_engine #(
      .UNITS  (UNITS),
      .UNIT_W (UNIT_W)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_unit     (req_unit),
      .req_write    (req_write),
      .timing_words (timing_words),
      .mode_bits    (mode_bits),
      .iordy_s      (iordy_s),
      .req_ready    (req_ready),
      .strobe_rd    (strobe_rd),
      .strobe_wr    (strobe_wr),
      .cycle_done   (cycle_done)
   );

endmodule

// File: tb/tb_pio_strobe_gen.sv
module tb_pio_strobe_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [1:0]  wbuf_busy = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_unit = '0;
   logic        req_write = 1'b0;
   logic        iordy = 1'b1;
   logic        req_ready, strobe_rd, strobe_wr, cycle_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pio_strobe_gen dut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
      .cfg_wdata (cfg_wdata), .wbuf_busy (wbuf_busy), .req_valid (req_valid),
      .req_unit (req_unit), .req_write (req_write), .iordy (iordy),
      .req_ready (req_ready), .strobe_rd (strobe_rd), .strobe_wr (strobe_wr),
      .cycle_done (cycle_done)
   );

   // vector: unit, write, word, expected active, expected recovery
   localparam int NVEC = 8;
   localparam logic [28:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 16'h0000, 5'd17, 5'd16},
      {2'd1, 1'b1, 16'h3A00, 5'd7,  5'd13},
      {2'd2, 1'b0, 16'h12F5, 5'd12, 5'd1 },
      {2'd3, 1'b1, 16'hEF00, 5'd2,  5'd2 },
      {2'd3, 1'b0, 16'h0088, 5'd9,  5'd8 },
      {2'd1, 1'b0, 16'hFF0F, 5'd2,  5'd16},
      {2'd2, 1'b1, 16'h7C21, 5'd5,  5'd9 },
      {2'd0, 1'b1, 16'h0000, 5'd17, 5'd16}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // runs one cycle; widths counted in falling-edge samples
   task automatic run_cycle(input logic [1:0] u, input bit w, input int iordy_j,
                            input bit mid_wr, input logic [15:0] mid_word,
                            input bit mid_req, output int act, output int rec,
                            output int bad_dir);
      @(negedge clk);
      req_valid = 1'b1; req_unit = u; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      act = 0; rec = 0; bad_dir = 0;
      while ((strobe_rd || strobe_wr) && act < 200) begin
         act++;
         if (w ? (!strobe_wr || strobe_rd) : (!strobe_rd || strobe_wr)) bad_dir++;
         if (act == iordy_j + 1) iordy = 1'b1;
         if (mid_req && act == 2) begin
            req_valid = 1'b1; req_unit = u ^ 2'd1; req_write = !w;
         end
         if (act == 3) req_valid = 1'b0;
         if (mid_wr && act == 3) begin
            cfg_we = 1'b1; cfg_addr = 8'h44 + 8'(2 * u); cfg_wdata = mid_word;
         end
         if (act == 4) cfg_we = 1'b0;
         @(negedge clk);
      end
      cfg_we = 1'b0; req_valid = 1'b0;
      while (rec < 200) begin
         rec++;
         if (cycle_done) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int a, r, bd;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R1 ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check({strobe_rd, strobe_wr, cycle_done} === 3'b000, "R1 outputs idle",
            int'({strobe_rd, strobe_wr, cycle_done}), 0);

      // R1: unprogrammed units use the slowest timing
      run_cycle(2'd2, 1'b0, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 17, "R1 default active", a, 17);
      check(r == 16, "R1 default recovery", r, 16);
      run_cycle(2'd3, 1'b1, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 17, "R1 default active write", a, 17);

      // table walk: R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  vu;
         logic        vw;
         logic [15:0] vword;
         int          ea, er;
         vu = VEC[i][28:27]; vw = VEC[i][26]; vword = VEC[i][25:10];
         ea = int'(VEC[i][9:5]); er = int'(VEC[i][4:0]);
         cfg_write(8'h44 + 8'(2 * vu), vword);
         run_cycle(vu, vw, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
         check(a == ea, $sformatf("R3 R5 active vec %0d", i), a, ea);
         check(r == er, $sformatf("R4 R5 recovery vec %0d", i), r, er);
         check(bd == 0, $sformatf("R6 strobe select vec %0d", i), bd, 0);
         check(req_ready && !cycle_done, $sformatf("R10 idle after vec %0d", i),
               int'(req_ready), 1);
      end

      // R2: units keep separate words
      cfg_write(8'h44, 16'h000F);
      cfg_write(8'h46, 16'h0008);
      run_cycle(2'd0, 1'b0, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 2, "R2 unit0 word", a, 2);
      run_cycle(2'd1, 1'b0, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 9, "R2 unit1 word", a, 9);

      // R7: IORDY stretch, mode bit clear
      cfg_write(8'h44, 16'h000F);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd0, 1'b0, 20, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 23, "R7 stretched active", a, 23);
      check(r == 16, "R7 recovery after stretch", r, 16);
      cfg_write(8'h48, 16'h0000);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd2, 1'b0, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 17, "R7 early release keeps minimum", a, 17);

      // R9: mode write while busy is held back
      wbuf_busy = 2'b01;
      cfg_write(8'h42, 16'h0010);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd0, 1'b0, 10, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 13, "R9 mode deferred while busy", a, 13);
      wbuf_busy = 2'b00;
      iordy = 1'b0; repeat (4) @(negedge clk);
      // R8: bit 4 set, unit 0 ignores IORDY
      run_cycle(2'd0, 1'b0, 999, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 2, "R8 R9 IORDY ignored after drain", a, 2);
      // R8: other units still honour IORDY
      cfg_write(8'h46, 16'h000F);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd1, 1'b0, 4, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 7, "R8 unit1 still stretched", a, 7);
      // R9: write with buffers clear applies at once
      cfg_write(8'h42, 16'h0000);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd0, 1'b0, 5, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 8, "R9 immediate mode write", a, 8);
      iordy = 1'b1; repeat (4) @(negedge clk);

      // R11 + R10: mid-cycle write and ignored request
      cfg_write(8'h46, 16'h0000);
      run_cycle(2'd1, 1'b0, 0, 1'b1, 16'h00FF, 1'b1, a, r, bd);
      check(a == 17, "R11 current cycle active kept", a, 17);
      check(r == 16, "R11 current cycle recovery kept", r, 16);
      check(req_ready && !strobe_rd && !strobe_wr, "R10 busy request ignored",
            int'({strobe_rd, strobe_wr}), 0);
      run_cycle(2'd1, 1'b0, 0, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 2, "R11 next cycle active", a, 2);
      check(r == 1, "R11 next cycle recovery", r, 1);

      // R12: stray addresses change nothing
      cfg_write(8'h44, 16'h0000);
      cfg_write(8'h40, 16'hFFFF);
      cfg_write(8'h43, 16'hFFFF);
      cfg_write(8'h4C, 16'hFFFF);
      cfg_write(8'h45, 16'hFFFF);
      iordy = 1'b0; repeat (4) @(negedge clk);
      run_cycle(2'd0, 1'b0, 20, 1'b0, 16'h0, 1'b0, a, r, bd);
      check(a == 23, "R12 timing and mode untouched", a, 23);
      check(r == 16, "R12 recovery untouched", r, 16);
      iordy = 1'b1;

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule